// File: doc/BRIEF.md
# Scanned LED Matrix Grayscale Refresh Controller

This block refreshes a row-multiplexed LED matrix. The columns hang off an external serial-input grayscale PWM sink with one channel per column. The rows are selected by an external shift register that has its own data and clock lines. One matrix row is shown for each grayscale period. For each row the controller reads the row's pixels from a frame buffer port. It passes each 8-bit pixel through a brightness curve that yields a 12-bit level, and shifts the levels out most significant bit first on a data line paced by a shift clock.

Once a row is fully shifted, the controller hands it over to the display. It blanks the column sink, waits for the drivers to switch off, and clocks the row register. It waits again, pulses the latch and removes the blank. The controller also produces the grayscale reference clock and counts it. At the end of every period it pulses blank to restart the sink's PWM counter. The same period-end event starts the load of the next row, and the counter restarts at each unblank so that every row gets a full period.

The frame buffer port is a combinational read: the pixel input must reflect the row and column addresses in the same cycle.

Top module: `led_scan_ctrl`

## Requirements
- R1: While the synchronous active-high reset is applied, `col_blank` is 1, `col_sdata`, `col_sclk`, `col_latch`, `row_clk` and `row_data` are 0, and `fb_row` is 0.
- R2: Between two latch pulses there are exactly NUM_COLS×WORD_W rising edges of `col_sclk` (192 by default). These carry one WORD_W-bit word per column, column 0 first, each word most significant bit first.
- R3: The word for pixel x is x when x ≤ LIN_END. Otherwise it is x + floor((x−LIN_END)²·(TOP_VAL−255)/(255−LIN_END)²). With the defaults this makes 0→0, 26→26, 27→27 and 255→4094.
- R4: `col_sdata` holds its value in the cycle before each rising edge of `col_sclk` and while `col_sclk` is high.
- R5: Handover order: `col_blank` rises first. `row_clk` rises SETTLE_PRE+1 cycles after that. `col_latch` is high for one cycle, SETTLE_POST+1 cycles after the rise of `row_clk`, while blank is still high. `col_blank` is 0 in the cycle after the latch.
- R6: Rows are loaded in the order 0, 1, … NUM_ROWS−1, then 0 again. Each handover gives exactly one `row_clk` pulse. The `row_data` value sampled at that pulse is 1 only when the row being loaded is row 0.
- R7: `row_clk` and `row_data` are low outside the handover. Per handover, `row_clk` is high for one cycle and `row_data` is high for two cycles (set-up and clock) only for row 0.
- R8: `gs_clk` toggles every clock cycle outside a restart. At each grayscale period end, `col_blank` pulses high for exactly one cycle.
- R9: The grayscale counter restarts at the latch. The next period-end blank pulse falls on exactly the GS_PERIOD-th rising edge of `gs_clk` after the latch.
- R10: The shifting of a new row starts only after a period-end pulse. No `col_sclk` edge occurs between a latch and the next period-end pulse.
- R11: Within a row, consecutive `col_sclk` rising edges are exactly two cycles apart, with no gap between words.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| fb_row | output | ROW_W | Frame buffer row address (row being loaded) |
| fb_col | output | COL_W | Frame buffer column address |
| fb_pixel | input | PIX_W | Pixel value at the addressed location |
| col_sdata | output | 1 | Serial data to the column sink |
| col_sclk | output | 1 | Shift clock to the column sink |
| col_blank | output | 1 | Blank to the column sink, high = outputs off |
| col_latch | output | 1 | Latch pulse to the column sink |
| gs_clk | output | 1 | Grayscale reference clock |
| row_data | output | 1 | Serial data to the row shift register |
| row_clk | output | 1 | Clock to the row shift register |

## Verification
The bench builds the controller with NUM_ROWS = 3, GS_PERIOD = 256, SETTLE_PRE = 3 and SETTLE_POST = 6, with the column count and word width left at their defaults. A row count that is not a power of two makes the wrap from the last row back to row 0 depend on the compare, not on counter overflow. The short grayscale period lets several full frames, and two wraps, fit in a few thousand cycles. Distinct settle lengths make the exact handover spacing observable. The pixel patterns cover the curve's linear segment, its first curved point and both endpoints. The frame data changes between frames.

// File: rtl/led_scan_pkg.sv
package led_scan_pkg;

    typedef enum logic [3:0] {
        SC_FETCH,
        SC_PRIME,
        SC_SHIFT,
        SC_PRE,
        SC_ROWSET,
        SC_ROWCLK,
        SC_POST,
        SC_LATCH,
        SC_WAIT
    } scan_st_e;

endpackage

// File: rtl/lsc_curve_rom.sv
module lsc_curve_rom #(
    parameter int PIX_W   = 8,
    parameter int WORD_W  = 12,
    parameter int LIN_END = 26,
    parameter int TOP_VAL = 4094
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [PIX_W-1:0]  pix,
    output logic [WORD_W-1:0] level
);
    localparam int MAXIN = (1 << PIX_W) - 1;
    localparam int SPAN  = TOP_VAL - MAXIN;
    localparam int DEN   = (MAXIN - LIN_END) * (MAXIN - LIN_END);

    logic [WORD_W-1:0] level_d, level_q;

    always_comb begin
        int x;
        int dd;
        int val;
        x  = int'(pix);
        dd = x - LIN_END;
        if (x <= LIN_END) val = x;
        else              val = x + (dd * dd * SPAN) / DEN;
        level_d = WORD_W'(val);
    end

    always_ff @(posedge clk) begin
        if (rst) level_q <= '0;
        else     level_q <= level_d;
    end

    assign level = level_q;

    // R3: the top input reaches the top level one cycle later
    assert_curve_top_R3: assert property (@(posedge clk) disable iff (rst)
        (pix == PIX_W'(MAXIN)) |=> (level == WORD_W'(TOP_VAL)));
    // R3: black stays black
    assert_curve_zero_R3: assert property (@(posedge clk) disable iff (rst)
        (pix == '0) |=> (level == '0));

endmodule

// File: rtl/lsc_gs_timer.sv
module lsc_gs_timer #(
    parameter int GS_PERIOD = 4096
) (
    input  logic clk,
    input  logic rst,
    input  logic restart,
    output logic gs_clk,
    output logic period_end
);
    localparam int CNT_W = $clog2(GS_PERIOD);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(GS_PERIOD - 1);

    typedef struct packed {
        logic             tick;
        logic [CNT_W-1:0] cnt;
    } gs_t;

    gs_t q, d;

    always_comb begin
        d = q;
        if (restart) begin
            d.tick = 1'b0;
            d.cnt  = '0;
        end else begin
            d.tick = ~q.tick;
            if (!q.tick) d.cnt = (q.cnt == LAST) ? '0 : q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) q <= '0;
        else     q <= d;
    end

    assign gs_clk     = q.tick;
    assign period_end = !restart && !q.tick && (q.cnt == LAST);

    // R8: a period end is followed by a rising reference clock and a wrapped count
    assert_gs_wrap_R8: assert property (@(posedge clk) disable iff (rst)
        period_end |=> (gs_clk && q.cnt == '0));
    // R9: a restart leaves the counter at zero with the clock low
    assert_gs_restart_R9: assert property (@(posedge clk) disable iff (rst)
        restart |=> (!gs_clk && q.cnt == '0));

endmodule

// File: rtl/led_scan_ctrl.sv
module led_scan_ctrl
    import led_scan_pkg::*;
#(
    parameter int NUM_COLS    = 16,
    parameter int WORD_W      = 12,
    parameter int PIX_W       = 8,
    parameter int NUM_ROWS    = 16,
    parameter int GS_PERIOD   = 4096,
    parameter int SETTLE_PRE  = 10,
    parameter int SETTLE_POST = 20,
    parameter int LIN_END     = 26,
    parameter int TOP_VAL     = 4094,
    localparam int COL_W      = $clog2(NUM_COLS),
    localparam int ROW_W      = (NUM_ROWS > 1) ? $clog2(NUM_ROWS) : 1
) (
    input  logic             clk,
    input  logic             rst,
    output logic [ROW_W-1:0] fb_row,
    output logic [COL_W-1:0] fb_col,
    input  logic [PIX_W-1:0] fb_pixel,
    output logic             col_sdata,
    output logic             col_sclk,
    output logic             col_blank,
    output logic             col_latch,
    output logic             gs_clk,
    output logic             row_data,
    output logic             row_clk
);
    localparam int BIT_W   = $clog2(WORD_W);
    localparam int SET_MAX = (SETTLE_PRE > SETTLE_POST) ? SETTLE_PRE : SETTLE_POST;
    localparam int SET_W   = $clog2(SET_MAX + 1);

    typedef struct packed {
        scan_st_e          st;
        logic [COL_W-1:0]  col;
        logic [BIT_W-1:0]  bitn;
        logic              ph;
        logic [WORD_W-1:0] sh;
        logic [ROW_W-1:0]  row;
        logic              live;
        logic              pulse;
        logic [SET_W-1:0]  cnt;
    } scan_t;

    scan_t q, d;

    logic              period_end;
    logic              restart;
    logic [WORD_W-1:0] level;
    logic              handover;

    lsc_gs_timer #(.GS_PERIOD(GS_PERIOD)) u_gs (
        .clk        (clk),
        .rst        (rst),
        .restart    (restart),
        .gs_clk     (gs_clk),
        .period_end (period_end)
    );

    lsc_curve_rom #(
        .PIX_W   (PIX_W),
        .WORD_W  (WORD_W),
        .LIN_END (LIN_END),
        .TOP_VAL (TOP_VAL)
    ) u_curve (
        .clk   (clk),
        .rst   (rst),
        .pix   (fb_pixel),
        .level (level)
    );

    assign restart = (q.st == SC_LATCH);

    always_comb begin
        d       = q;
        d.pulse = period_end;
        case (q.st)
            SC_WAIT: begin
                if (period_end) begin
                    d.st  = SC_FETCH;
                    d.row = (int'(q.row) == NUM_ROWS - 1) ? '0 : q.row + 1'b1;
                end
            end
            SC_FETCH: d.st = SC_PRIME;
            SC_PRIME: begin
                d.st   = SC_SHIFT;
                d.sh   = level;
                d.col  = '0;
                d.bitn = '0;
                d.ph   = 1'b0;
            end
            SC_SHIFT: begin
                if (!q.ph) begin
                    d.ph = 1'b1;
                end else begin
                    d.ph = 1'b0;
                    if (q.bitn == BIT_W'(WORD_W - 1)) begin
                        d.bitn = '0;
                        if (q.col == COL_W'(NUM_COLS - 1)) begin
                            d.st  = SC_PRE;
                            d.cnt = '0;
                        end else begin
                            d.col = q.col + 1'b1;
                            d.sh  = level;
                        end
                    end else begin
                        d.bitn = q.bitn + 1'b1;
                        d.sh   = {q.sh[WORD_W-2:0], 1'b0};
                    end
                end
            end
            SC_PRE: begin
                if (q.cnt == SET_W'(SETTLE_PRE - 1)) begin
                    d.st  = SC_ROWSET;
                    d.cnt = '0;
                end else begin
                    d.cnt = q.cnt + 1'b1;
                end
            end
            SC_ROWSET: d.st = SC_ROWCLK;
            SC_ROWCLK: begin
                d.st  = SC_POST;
                d.cnt = '0;
            end
            SC_POST: begin
                if (q.cnt == SET_W'(SETTLE_POST - 1)) d.st = SC_LATCH;
                else                                  d.cnt = q.cnt + 1'b1;
            end
            SC_LATCH: begin
                d.st   = SC_WAIT;
                d.live = 1'b1;
            end
            default: d.st = SC_WAIT;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            q    <= '0;
            q.st <= SC_FETCH;
        end else begin
            q <= d;
        end
    end

    assign handover  = (q.st == SC_PRE) || (q.st == SC_ROWSET) || (q.st == SC_ROWCLK)
                    || (q.st == SC_POST) || (q.st == SC_LATCH);
    assign fb_row    = q.row;
    assign fb_col    = (q.st == SC_SHIFT) ? q.col + 1'b1 : '0;
    assign col_sdata = (q.st == SC_SHIFT) && q.sh[WORD_W-1];
    assign col_sclk  = (q.st == SC_SHIFT) && q.ph;
    assign col_latch = (q.st == SC_LATCH);
    assign col_blank = !q.live || handover || q.pulse;
    assign row_clk   = (q.st == SC_ROWCLK);
    assign row_data  = ((q.st == SC_ROWSET) || (q.st == SC_ROWCLK)) && (q.row == '0);

    // R4: data does not move at a shift clock rise
    assert_sdata_setup_R4: assert property (@(posedge clk) disable iff (rst)
        $rose(col_sclk) |-> $stable(col_sdata));
    // R11: shift clock high lasts one cycle
    assert_sclk_width_R11: assert property (@(posedge clk) disable iff (rst)
        col_sclk |=> !col_sclk);
    // R5: latch and row clock only while blanked, unblank right after the latch
    assert_latch_blanked_R5: assert property (@(posedge clk) disable iff (rst)
        col_latch |-> col_blank);
    assert_unblank_R5: assert property (@(posedge clk) disable iff (rst)
        col_latch |=> !col_blank);
    assert_rowclk_blanked_R5: assert property (@(posedge clk) disable iff (rst)
        row_clk |-> col_blank);
    // R7: row data is steady at the row clock edge
    assert_rowdata_hold_R7: assert property (@(posedge clk) disable iff (rst)
        $rose(row_clk) |-> $stable(row_data));
    // R6: row index stays inside the matrix
    assert_row_range_R6: assert property (@(posedge clk) disable iff (rst)
        int'(fb_row) < NUM_ROWS);
    // R10: period ends only arrive while waiting for them
    assert_trigger_wait_R10: assert property (@(posedge clk) disable iff (rst)
        period_end |-> (q.st == SC_WAIT));

endmodule

// File: tb/sim_led_scan_ctrl.sv
`timescale 1ns/1ps
module sim_led_scan_ctrl;
    localparam int NR   = 3;
    localparam int GSP  = 256;
    localparam int PRE  = 3;
    localparam int POST = 6;
    localparam int NC   = 16;
    localparam int WW   = 12;
    localparam int NB   = NC * WW;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #2.5 clk = ~clk;

    logic [1:0] fb_row;
    logic [3:0] fb_col;
    logic [7:0] fb_pixel;
    logic col_sdata, col_sclk, col_blank, col_latch, gs_clk, row_data, row_clk;
    logic [7:0] fb [4][16];

    assign fb_pixel = fb[fb_row][fb_col];

    led_scan_ctrl #(
        .NUM_ROWS(NR), .GS_PERIOD(GSP), .SETTLE_PRE(PRE), .SETTLE_POST(POST)
    ) u0 (
        .clk(clk), .rst(rst), .fb_row(fb_row), .fb_col(fb_col), .fb_pixel(fb_pixel),
        .col_sdata(col_sdata), .col_sclk(col_sclk), .col_blank(col_blank),
        .col_latch(col_latch), .gs_clk(gs_clk), .row_data(row_data), .row_clk(row_clk)
    );

    int checks = 0;
    int errors = 0;
    logic c_sclk = 0, c_sdata = 0, c_blank = 0, c_latch = 0, c_gs = 0, c_rd = 0, c_rc = 0;
    logic p_sclk = 0, p_sdata = 0, p_blank = 0, p_latch = 0, p_gs = 0, p_rd = 0, p_rc = 0;

    task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic smp();
        @(negedge clk);
        p_sclk = c_sclk; p_sdata = c_sdata; p_blank = c_blank; p_latch = c_latch;
        p_gs = c_gs; p_rd = c_rd; p_rc = c_rc;
        c_sclk = col_sclk; c_sdata = col_sdata; c_blank = col_blank; c_latch = col_latch;
        c_gs = gs_clk; c_rd = row_data; c_rc = row_clk;
    endtask

    function automatic int curve_f(input int x);
        if (x <= 26) return x;
        return x + ((x - 26) * (x - 26) * 3839) / 52441;
    endfunction

    // Reset state (R1)
    task automatic test_reset();
        rst = 1'b1;
        repeat (3) @(posedge clk);
        smp();
        chk(col_blank == 1'b1, "R1 blank in reset", col_blank, 1);
        chk({col_sdata, col_sclk, col_latch, row_clk, row_data} == 5'b0,
            "R1 serial outputs low in reset", {col_sdata, col_sclk, col_latch, row_clk, row_data}, 0);
        chk(fb_row == 2'd0, "R1 row counter zero", fb_row, 0);
        rst = 1'b0;
    endtask

    // Captures one row from its load trigger up to its latch and checks it
    task automatic capture_row(input int exp_row, input bit timed, input string name);
        logic bits [NB];
        int nbits = 0, t = 0, gs_r = 0, pulse_r = -1, pulse_t = -10;
        int brise_t = -1, rc_t = -1, rc_bits = -1, lat_t = -1, last_t = -1;
        int rc_n = 0, rd_n = 0, rch_n = 0, gaps = 0, early = 0, setup_bad = 0, mism = 0;
        int bad_word = 0, bad_exp = 0;
        bit pulse_seen = 0, done = 0, rc_val = 0, lat_blank = 0;
        while (!done) begin
            smp();
            t++;
            if (t > 4 * GSP * 2) begin
                chk(1'b0, {"R2 latch never reached ", name}, t, 0);
                return;
            end
            if (c_gs && !p_gs && !pulse_seen) gs_r++;
            if (c_blank && !p_blank) begin
                if (nbits == 0 && !pulse_seen) begin
                    pulse_seen = 1; pulse_r = gs_r; pulse_t = t;
                end else if (nbits == NB) begin
                    brise_t = t;
                end
            end
            if (pulse_seen && t == pulse_t + 1)
                chk(!c_blank, {"R8 period blank pulse one cycle ", name}, c_blank, 0);
            if (c_sclk && !p_sclk) begin
                if (!pulse_seen) early++;
                if (c_sdata != p_sdata) setup_bad++;
                if (nbits < NB) bits[nbits] = c_sdata;
                nbits++;
                if (last_t >= 0 && t - last_t != 2) gaps++;
                last_t = t;
            end
            if (c_sclk && c_sdata != p_sdata) setup_bad++;
            if (c_rc && !p_rc) begin
                rc_n++; rc_t = t; rc_bits = nbits; rc_val = c_rd;
            end
            if (c_rd) rd_n++;
            if (c_rc) rch_n++;
            if (c_latch) begin
                done = 1; lat_t = t; lat_blank = c_blank;
            end
        end
        smp();
        chk(!c_blank, {"R5 unblank after latch ", name}, c_blank, 0);
        chk(lat_blank, {"R5 latch while blanked ", name}, lat_blank, 1);
        chk(nbits == NB, {"R2 shift clock count ", name}, nbits, NB);
        for (int c = 0; c < NC; c++) begin
            int w = 0;
            for (int b = 0; b < WW; b++) w = (w << 1) | int'(bits[c * WW + b]);
            if (w != curve_f(int'(fb[exp_row][c]))) begin
                if (mism == 0) begin bad_word = w; bad_exp = curve_f(int'(fb[exp_row][c])); end
                mism++;
            end
        end
        chk(mism == 0, {"R3 column words MSB first ", name}, bad_word, bad_exp);
        chk(setup_bad == 0, {"R4 data steady at shift clock ", name}, setup_bad, 0);
        chk(gaps == 0, {"R11 shift clock spacing ", name}, gaps, 0);
        chk(rc_n == 1 && rc_bits == NB, {"R6 one row clock after full shift ", name}, rc_n, 1);
        chk(rc_val == (exp_row == 0), {"R6 row data bit ", name}, rc_val, exp_row == 0);
        chk(rch_n == 1 && rd_n == ((exp_row == 0) ? 2 : 0), {"R7 row lines idle low ", name},
            rd_n, (exp_row == 0) ? 2 : 0);
        if (timed) begin
            chk(rc_t - brise_t == PRE + 1, {"R5 blank to row clock ", name}, rc_t - brise_t, PRE + 1);
            chk(lat_t - rc_t == POST + 1, {"R5 row clock to latch ", name}, lat_t - rc_t, POST + 1);
            chk(pulse_seen && pulse_r == GSP, {"R9 period after latch ", name}, pulse_r, GSP);
            chk(early == 0, {"R10 no shifting before period end ", name}, early, 0);
        end
    endtask

    task automatic fill_frame(input int seed);
        for (int r = 0; r < 4; r++)
            for (int c = 0; c < NC; c++)
                fb[r][c] = 8'((c * 17 + r * 53 + seed * 29) ^ (seed * 7));
    endtask

    // First frame after reset, then the wrap to row 0 (R6)
    task automatic test_first_frame();
        fill_frame(1);
        fb[0][0] = 8'd0;   fb[0][1] = 8'd26;  fb[0][2] = 8'd27;  fb[0][3] = 8'd255;
        fb[0][4] = 8'd1;   fb[0][5] = 8'd128; fb[0][6] = 8'd254; fb[0][7] = 8'd25;
        capture_row(0, 1'b0, "frame1 row0");
        capture_row(1, 1'b1, "frame1 row1");
        capture_row(2, 1'b1, "frame1 row2");
    endtask

    task automatic test_wrap_new_data();
        fill_frame(5);
        capture_row(0, 1'b1, "frame2 row0 wrap");
        capture_row(1, 1'b1, "frame2 row1");
    endtask

    // Curve endpoints and linear segment across a whole row (R3)
    task automatic test_curve_points();
        for (int c = 0; c < NC; c++) fb[2][c] = (c < 8) ? 8'(c * 3 + 3) : 8'(255 - (c - 8));
        for (int c = 0; c < NC; c++) fb[0][c] = (c[0]) ? 8'd255 : 8'd0;
        capture_row(2, 1'b1, "curve row2");
        capture_row(0, 1'b1, "curve row0 second wrap");
    endtask

    initial begin
        for (int r = 0; r < 4; r++)
            for (int c = 0; c < NC; c++) fb[r][c] = 8'd0;
        test_reset();
        test_first_frame();
        test_wrap_new_data();
        test_curve_points();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog all requirements actual=%0d expected=%0d", 150000, 0);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule